// File: doc/BRIEF.md
# Reset Boot and Clock-Mode Selector

This block turns a raw, level-sensitive reset pin into a clean internal reset. The internal reset is asserted only after the pin has stayed high for a set number of machine-cycle ticks. When the internal reset is released, the block decides once where execution starts: at the user vector (address 0000H) or in the boot loader. Two things pick the boot loader. The first is a persisted status byte that is not zero. The second is a pin-strap pattern on three configuration pins that are sampled at the moment of release.

The block also resolves the clock divider mode. A persisted configuration bit, when programmed, forces divide-by-6 operation. When it is erased, a software control bit chooses between divide-by-12 and divide-by-6.

The status byte and the configuration bit are modelled as a small store. It has a byte write port, a program strobe for the configuration bit, and a chip-erase input that puts both back to their erased defaults. The active-low `rst_ni` stands for power-on and also loads the erased defaults.

Top module: `boot_clk_sel`

## Requirements
- R1: `rst_o` rises in the cycle after the second `mc_tick_i` that is sampled while the synchronised reset pin is high. A pin-high period that ends before two ticks does not assert it, and the tick count restarts from zero whenever the synchronised pin is low. `rst_o` clears on the first clock edge at which the synchronised pin is low. The pin reaches the synchroniser through two flops.
- R2: At internal reset release, a status byte of 00h selects user start (`boot_sel_o`=0) and any non-zero value selects the boot loader (`boot_sel_o`=1).
- R3: A strap pattern forces `boot_sel_o`=1 whatever the status byte holds. The pattern is `strobe_n_i`=0, `ext_acc_i`=1 and `latch_en_i`=1, sampled through two-flop synchronisers in the release cycle. Any other combination leaves the choice to the status byte.
- R4: The status byte powers up as FFh. A write through `stat_we_i` is accepted only while the stored value is non-zero, so once it holds 00h every write is ignored. `chip_erase_i` restores FFh and wins over a write in the same cycle. `stat_o` shows the stored value one cycle after the update.
- R5: With the configuration bit erased, `div6_o` follows `x2_i` one clock later: 0 means divide-by-12 and 1 means divide-by-6.
- R6: With the configuration bit programmed (by `fx2_prog_i`) and taken at a reset release, `div6_o` is 1 whatever `x2_i` is.
- R7: `chip_erase_i` erases the configuration bit. After the next reset release, `div6_o` is 0 while `x2_i`=0.
- R8: `boot_sel_o` and the configuration-bit part of `div6_o` change only at an internal reset release. Status writes, configuration programming, erase and strap changes made at run time take effect only after the next release.
- R9: While `rst_ni` is low: `rst_o`=1, `boot_sel_o`=1, `div6_o`=0, `stat_o`=FFh, and the configuration bit is erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| rst_pin_i | input | 1 | Raw external reset pin, active high |
| mc_tick_i | input | 1 | One-cycle pulse per machine cycle |
| strobe_n_i | input | 1 | Program-store strobe pin level, active low |
| ext_acc_i | input | 1 | External-access pin level |
| latch_en_i | input | 1 | Address-latch-enable pin level (pulled up when floating) |
| stat_we_i | input | 1 | Status byte write strobe |
| stat_wdata_i | input | 8 | Status byte write data |
| fx2_prog_i | input | 1 | Program the clock-mode configuration bit |
| chip_erase_i | input | 1 | Full erase: status byte to FFh, configuration bit erased |
| x2_i | input | 1 | Software clock-mode bit |
| rst_o | output | 1 | Internal reset, active high |
| boot_sel_o | output | 1 | Start select: 1 boot loader, 0 user vector 0000H |
| div6_o | output | 1 | 1 divide-by-6, 0 divide-by-12 |
| stat_o | output | 8 | Stored status byte |

## Verification
The assertions assume that `mc_tick_i` is a pulse of at most one cycle. They also assume that the strap pins hold steady through the synchroniser depth around each release, since a strap that moves in the release window can be sampled either way. The bench drives every input on the falling clock edge. It holds the straps for several cycles before lowering the reset pin and keeps them until after release. It pulses the tick for exactly one cycle at a time, with idle cycles between pulses.

// File: rtl/boot_clk_pkg.sv
package boot_clk_pkg;
  localparam logic [7:0] STAT_ERASED = 8'hFF;
  localparam logic [7:0] STAT_USER   = 8'h00;

  typedef struct packed {
    logic strobe_n;
    logic ext_acc;
    logic latch_en;
  } strap_t;

  localparam strap_t STRAP_IDLE = '{strobe_n: 1'b1, ext_acc: 1'b0, latch_en: 1'b0};

  function automatic logic strap_forces_boot(strap_t s);
    return ~s.strobe_n & s.ext_acc & s.latch_en;
  endfunction
endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bcs_rst_filter.sv
module bcs_rst_filter #(
  parameter int unsigned HOLD_MC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  output logic rst_o,
  output logic rel_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_MC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_MC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rst_q;
  logic             hit;

  assign hit = pin_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!pin_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // power-on leaves the internal reset asserted until the pin is seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rst_q <= 1'b1;
    else if (!pin_i) rst_q <= 1'b0;
    else if (hit)    rst_q <= 1'b1;
  end

  assign rst_o = rst_q;
  assign rel_o = rst_q & ~pin_i;
endmodule

// File: rtl/bcs_nv_store.sv
module bcs_nv_store
  import boot_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stat_we_i,
  input  logic [7:0] stat_wdata_i,
  input  logic       fx2_prog_i,
  input  logic       chip_erase_i,
  output logic [7:0] stat_o,
  output logic       fx2_o
);
  logic [7:0] stat_q;
  logic       fx2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_ERASED;
      fx2_q  <= 1'b0;
    end else if (chip_erase_i) begin
      stat_q <= STAT_ERASED;
      fx2_q  <= 1'b0;
    end else begin
      // a cleared status byte is sticky until a full erase
      if (stat_we_i && stat_q != STAT_USER) stat_q <= stat_wdata_i;
      if (fx2_prog_i) fx2_q <= 1'b1;
    end
  end

  assign stat_o = stat_q;
  assign fx2_o  = fx2_q;
endmodule

// File: rtl/bcs_boot_cap.sv
module bcs_boot_cap
  import boot_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rel_i,
  input  strap_t     strap_i,
  input  logic [7:0] stat_i,
  input  logic       fx2_i,
  input  logic       x2_i,
  output logic       strap_hit_o,
  output logic       fx2_eff_o,
  output logic       boot_sel_o,
  output logic       div6_o
);
  logic boot_q, fx2_eff_q, div6_q;

  assign strap_hit_o = strap_forces_boot(strap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q    <= 1'b1;
      fx2_eff_q <= 1'b0;
    end else if (rel_i) begin
      boot_q    <= (stat_i != STAT_USER) | strap_hit_o;
      fx2_eff_q <= fx2_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div6_q <= 1'b0;
    else         div6_q <= fx2_eff_q | x2_i;
  end

  assign boot_sel_o = boot_q;
  assign fx2_eff_o  = fx2_eff_q;
  assign div6_o     = div6_q;
endmodule

// File: rtl/boot_clk_sel.sv
module boot_clk_sel
  import boot_clk_pkg::*;
#(
  parameter int unsigned HOLD_MC     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rst_pin_i,
  input  logic       mc_tick_i,
  input  logic       strobe_n_i,
  input  logic       ext_acc_i,
  input  logic       latch_en_i,
  input  logic       stat_we_i,
  input  logic [7:0] stat_wdata_i,
  input  logic       fx2_prog_i,
  input  logic       chip_erase_i,
  input  logic       x2_i,
  output logic       rst_o,
  output logic       boot_sel_o,
  output logic       div6_o,
  output logic [7:0] stat_o
);
  localparam int unsigned STRAP_W = $bits(strap_t);

  logic   pin_sync;
  logic   rel;
  logic   strap_hit;
  logic   fx2_nv;
  logic   fx2_eff;
  strap_t strap_raw, strap_sync;

  assign strap_raw = '{strobe_n: strobe_n_i, ext_acc: ext_acc_i, latch_en: latch_en_i};

  bcs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rst_pin_i),
    .q_o   (pin_sync)
  );

  bcs_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES), .RST_VAL(STRAP_IDLE)) i_strap_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (strap_raw),
    .q_o   (strap_sync)
  );

  bcs_rst_filter #(.HOLD_MC(HOLD_MC)) i_rst_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_sync),
    .tick_i(mc_tick_i),
    .rst_o (rst_o),
    .rel_o (rel)
  );

  bcs_nv_store i_nv_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stat_we_i   (stat_we_i),
    .stat_wdata_i(stat_wdata_i),
    .fx2_prog_i  (fx2_prog_i),
    .chip_erase_i(chip_erase_i),
    .stat_o      (stat_o),
    .fx2_o       (fx2_nv)
  );

  bcs_boot_cap i_boot_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rel_i      (rel),
    .strap_i    (strap_sync),
    .stat_i     (stat_o),
    .fx2_i      (fx2_nv),
    .x2_i       (x2_i),
    .strap_hit_o(strap_hit),
    .fx2_eff_o  (fx2_eff),
    .boot_sel_o (boot_sel_o),
    .div6_o     (div6_o)
  );
endmodule

// File: rtl/boot_clk_sel_chk.sv
module boot_clk_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mc_tick_i,
  input logic       chip_erase_i,
  input logic       rst_o,
  input logic       boot_sel_o,
  input logic       div6_o,
  input logic [7:0] stat_o,
  input logic       pin_sync,
  input logic       rel,
  input logic       strap_hit,
  input logic       fx2_eff
);
  p_rst_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(mc_tick_i) && $past(pin_sync));

  p_rst_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> !$past(pin_sync));

  p_user_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel && !strap_hit && stat_o == 8'h00) |=> !boot_sel_o);

  p_strap_boot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel && strap_hit) |=> boot_sel_o);

  p_status_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == 8'h00 && !chip_erase_i) |=> stat_o == 8'h00);

  p_erase_default_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_i |=> stat_o == 8'hFF);

  p_fx2_forces_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fx2_eff |=> div6_o);

  p_boot_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rel) |-> $stable(boot_sel_o));
endmodule

bind boot_clk_sel boot_clk_sel_chk i_boot_clk_sel_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mc_tick_i   (mc_tick_i),
  .chip_erase_i(chip_erase_i),
  .rst_o       (rst_o),
  .boot_sel_o  (boot_sel_o),
  .div6_o      (div6_o),
  .stat_o      (stat_o),
  .pin_sync    (pin_sync),
  .rel         (rel),
  .strap_hit   (strap_hit),
  .fx2_eff     (fx2_eff)
);

// File: tb/test_boot_clk_sel.sv
`timescale 1ns/1ps
module test_boot_clk_sel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rst_pin_i = 1'b0;
  logic       mc_tick_i = 1'b0;
  logic       strobe_n_i = 1'b1;
  logic       ext_acc_i = 1'b1;
  logic       latch_en_i = 1'b1;
  logic       stat_we_i = 1'b0;
  logic [7:0] stat_wdata_i = 8'h00;
  logic       fx2_prog_i = 1'b0;
  logic       chip_erase_i = 1'b0;
  logic       x2_i = 1'b0;
  logic       rst_o, boot_sel_o, div6_o;
  logic [7:0] stat_o;

  always #5 clk_i = ~clk_i;

  boot_clk_sel i_boot_clk_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_pin_i(rst_pin_i), .mc_tick_i(mc_tick_i),
    .strobe_n_i(strobe_n_i), .ext_acc_i(ext_acc_i), .latch_en_i(latch_en_i),
    .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i), .fx2_prog_i(fx2_prog_i),
    .chip_erase_i(chip_erase_i), .x2_i(x2_i), .rst_o(rst_o), .boot_sel_o(boot_sel_o),
    .div6_o(div6_o), .stat_o(stat_o)
  );

  typedef struct {
    string      tag;
    logic       rst;
    logic       boot;
    logic       div6;
    logic [7:0] stat;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // reference state, from the requirements
  logic [7:0] m_stat = 8'hFF;
  logic       m_fx2 = 1'b0;
  logic       m_fx2_eff = 1'b0;
  logic       m_boot = 1'b1;

  task automatic push(input string tag, input logic r, input logic b, input logic d, input logic [7:0] s);
    exp_t e;
    e.tag = tag; e.rst = r; e.boot = b; e.div6 = d; e.stat = s;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic expect_run(input string tag);
    push(tag, 1'b0, m_boot, m_fx2_eff | x2_i, m_stat);
  endtask

  // monitor: compares at the instant the driver posts, away from clock edges
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q[0];
      n_run++;
      if (rst_o !== e.rst || boot_sel_o !== e.boot || div6_o !== e.div6 || stat_o !== e.stat) begin
        n_fail++;
        $display("FAIL %s: got rst=%b boot=%b div6=%b stat=%h, expected rst=%b boot=%b div6=%b stat=%h",
                 e.tag, rst_o, boot_sel_o, div6_o, stat_o, e.rst, e.boot, e.div6, e.stat);
      end
      void'(exp_q.pop_front());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic tick();
    mc_tick_i = 1'b1; cyc(1); mc_tick_i = 1'b0;
  endtask

  task automatic do_reset(input logic sn, input logic ea, input logic al);
    strobe_n_i = sn; ext_acc_i = ea; latch_en_i = al;
    rst_pin_i = 1'b1; cyc(3);
    repeat (3) begin tick(); cyc(2); end
    rst_pin_i = 1'b0; cyc(5);
    m_boot = (m_stat != 8'h00) | (~sn & ea & al);
    m_fx2_eff = m_fx2;
    strobe_n_i = 1'b1; ext_acc_i = 1'b1; latch_en_i = 1'b1;
    cyc(1);
  endtask

  task automatic wr_stat(input logic [7:0] v);
    stat_wdata_i = v; stat_we_i = 1'b1; cyc(1); stat_we_i = 1'b0;
    if (m_stat != 8'h00) m_stat = v;
  endtask

  initial begin
    cyc(3);
    push("R9 power-on state", 1'b1, 1'b1, 1'b0, 8'hFF);
    rst_ni = 1'b1; cyc(4);
    expect_run("R9 release after power-on, erased status boots");

    // R1 reset filter
    rst_pin_i = 1'b1; cyc(10);
    expect_run("R1 pin high without ticks");
    tick();
    expect_run("R1 one tick is not enough");
    rst_pin_i = 1'b0; cyc(4);
    rst_pin_i = 1'b1; cyc(3);
    tick();
    expect_run("R1 count restarted after pin low");
    cyc(2); tick();
    push("R1 second tick asserts reset", 1'b1, m_boot, x2_i, m_stat);
    rst_pin_i = 1'b0; cyc(5);
    expect_run("R1 reset released");

    // R2 / R4 status byte
    wr_stat(8'h00);
    expect_run("R4 status cleared to 00h");
    expect_run("R8 boot select unchanged before reset");
    do_reset(1'b1, 1'b1, 1'b1);
    expect_run("R2 status 00h starts user code");
    wr_stat(8'h55);
    expect_run("R4 write ignored once status is 00h");
    do_reset(1'b1, 1'b1, 1'b1);
    expect_run("R4 ignored write leaves user start");

    // R3 straps
    do_reset(1'b0, 1'b1, 1'b1);
    expect_run("R3 strap pattern forces boot loader");
    do_reset(1'b1, 1'b1, 1'b1);
    expect_run("R3 strobe high: no force");
    do_reset(1'b0, 1'b0, 1'b1);
    expect_run("R3 ext_acc low: no force");
    do_reset(1'b0, 1'b1, 1'b0);
    expect_run("R3 latch_en low: no force");
    strobe_n_i = 1'b0; ext_acc_i = 1'b1; latch_en_i = 1'b1; cyc(6);
    expect_run("R8 strap at run time ignored");
    strobe_n_i = 1'b1;

    // R5 / R6 / R7 clock mode
    x2_i = 1'b1; cyc(1);
    expect_run("R5 x2=1 selects divide-by-6");
    x2_i = 1'b0; cyc(1);
    expect_run("R5 x2=0 selects divide-by-12");
    fx2_prog_i = 1'b1; cyc(1); fx2_prog_i = 1'b0; m_fx2 = 1'b1; cyc(1);
    expect_run("R8 programmed bit waits for reset");
    do_reset(1'b1, 1'b1, 1'b1);
    expect_run("R6 programmed bit forces divide-by-6");
    x2_i = 1'b1; cyc(1); x2_i = 1'b0; cyc(1);
    expect_run("R6 x2 toggle has no effect");
    chip_erase_i = 1'b1; cyc(1); chip_erase_i = 1'b0;
    m_stat = 8'hFF; m_fx2 = 1'b0;
    expect_run("R7 erase restores FFh, mode held until reset");
    do_reset(1'b1, 1'b1, 1'b1);
    expect_run("R7 after erase: divide-by-12, boot loader");

    // R4 writes while non-zero, erase priority
    wr_stat(8'h3C);
    expect_run("R4 write accepted while non-zero");
    do_reset(1'b1, 1'b1, 1'b1);
    expect_run("R2 non-zero status boots");
    stat_wdata_i = 8'h00; stat_we_i = 1'b1; chip_erase_i = 1'b1; cyc(1);
    stat_we_i = 1'b0; chip_erase_i = 1'b0; m_stat = 8'hFF;
    expect_run("R4 erase wins over same-cycle write");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule